// File: doc/BRIEF.md
# Processor Bus Decoder with ROM Wait-State Generation

This block decodes a byte-wide microprocessor bus with a 20-bit address. Its inputs are the latched address, a memory/IO select line and the active-low read and write strobes. It produces four active-low command strobes: memory read, memory write, I/O read and I/O write. It also produces active-low chip selects for three targets: a ROM bank at the top of memory, an SRAM bank at the bottom of memory, and a four-register peripheral block in I/O space. Outputs are gated by an active strobe, so nothing toggles while the bus is idle.

The ROM is slower than one bus cycle allows. Every ROM access therefore pulls a registered READY output low for exactly one clock. The ROM region is also split into 8 KB sub-selects by a 3-to-8 style decode, so that smaller parts can populate it. All other accesses run with no wait state.

Top module: `bus_decoder`

## Requirements
- R1: With only `rdN` low, the block drives `memRdN` low when `ioSel`=0 and `ioRdN` low when `ioSel`=1. With only `wrN` low, it drives `memWrN` or `ioWrN` low in the same way. At most one command strobe is low at a time.
- R2: When `rdN` and `wrN` are both high, or both low, the bus is idle. All command strobes and all chip selects are then high, and no wait state starts.
- R3: `romCsN` is low during a memory read or write whose address lies in F8000h to FFFFFh. This range includes the reset location FFFF0h.
- R4: `ramCsN` is low during a memory read or write whose address lies in 00000h to 7FFFFh.
- R5: A memory access in 80000h to F7FFFh asserts no chip select and no wait state.
- R6: `ppiCsN` is low only during an I/O read or write whose port `addr[15:0]` is 0060h to 0063h. `addr[19:16]` is ignored for I/O. A memory access at address 00060h selects SRAM and not the peripheral. `regSel` always carries `addr[1:0]`.
- R7: During a ROM select, exactly one bit of `romSubCsN` is low. Its index is `addr[15:13]`, so only indices 4 to 7 can occur. Outside a ROM select, all bits of `romSubCsN` are high.
- R8: A ROM access is first seen at a rising edge while READY is high and no wait is pending. READY goes low from that edge for exactly one clock, then stays high while the same access is held.
- R9: READY stays high throughout SRAM, peripheral and unmapped accesses.
- R10: While `rstN` is low, READY is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 20 | Latched address; I/O ports use bits 15..0 |
| ioSel | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| memRdN | output | 1 | Memory read command, active low |
| memWrN | output | 1 | Memory write command, active low |
| ioRdN | output | 1 | I/O read command, active low |
| ioWrN | output | 1 | I/O write command, active low |
| romCsN | output | 1 | ROM bank select, active low |
| ramCsN | output | 1 | SRAM bank select, active low |
| ppiCsN | output | 1 | Peripheral select, active low |
| romSubCsN | output | 8 | 8 KB ROM sub-selects, active low |
| regSel | output | 2 | Peripheral register select |
| ready | output | 1 | Wait request, low for one clock per ROM access |

## Verification
The combinational decode and the registered wait state coincide in the clock after a ROM strobe first appears. In that cycle `romCsN`, a sub-select and a low READY must all be present together. The bench provokes this coincidence in three ways: by holding ROM reads and writes for several clocks, by moving from a ROM access straight into an SRAM access with no idle cycle, and by re-entering ROM after one idle clock. For every clock it checks the predicted strobe, select and READY values together, so a wait that lasts one cycle too long, starts one cycle late or leaks onto SRAM is caught.

// File: rtl/bus_decoder_pkg.sv
package bus_decoder_pkg;
  // Internal active-high command strobes handed from control to datapath
  typedef struct packed {
    logic memRd;
    logic memWr;
    logic ioRd;
    logic ioWr;
  } cmdStrobes_t;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_WAIT = 2'd1,
    WS_HOLD = 2'd2
  } waitState_t;
endpackage

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl
  import bus_decoder_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ioSel,
  input  logic        rdN,
  input  logic        wrN,
  input  logic        romHit,
  output cmdStrobes_t cmd,
  output logic        ready
);
  logic rdActive;
  logic wrActive;
  waitState_t state, stateNext;

  // Both strobes low counts as idle
  assign rdActive = ~rdN & wrN;
  assign wrActive = rdN & ~wrN;

  always_comb begin
    cmd.memRd = rdActive & ~ioSel;
    cmd.memWr = wrActive & ~ioSel;
    cmd.ioRd  = rdActive & ioSel;
    cmd.ioWr  = wrActive & ioSel;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      WS_IDLE: if (romHit) stateNext = WS_WAIT;
      WS_WAIT: stateNext = romHit ? WS_HOLD : WS_IDLE;
      WS_HOLD: if (!romHit) stateNext = WS_IDLE;
      default: stateNext = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= WS_IDLE;
    else       state <= stateNext;
  end

  assign ready = (state != WS_WAIT);
endmodule

// File: rtl/bus_addr_dp.sv
module bus_addr_dp
  import bus_decoder_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int ROM_W      = 15,
  parameter int RAM_W      = 19,
  parameter int SUB_W      = 13,
  parameter int IO_W       = 16,
  parameter int PORT_SEL_W = 2,
  parameter logic [IO_W-1:0] PORT_BASE = 16'h0060
) (
  input  logic [ADDR_W-1:0]     addr,
  input  cmdStrobes_t           cmd,
  output logic                  romCsN,
  output logic                  ramCsN,
  output logic                  ppiCsN,
  output logic [7:0]            romSubCsN,
  output logic [PORT_SEL_W-1:0] regSel,
  output logic                  romHit
);
  localparam int DEC_N = 8;
  localparam int IDX_W = $clog2(DEC_N);

  logic memCycle;
  logic ioCycle;
  logic romRange;
  logic ramRange;
  logic portRange;
  // 3-to-8 style enables
  logic decG1;
  logic decG2aN;
  logic decG2bN;
  logic decEnable;
  logic [IDX_W-1:0] decIdx;

  assign memCycle = cmd.memRd | cmd.memWr;
  assign ioCycle  = cmd.ioRd | cmd.ioWr;

  assign romRange  = &addr[ADDR_W-1:ROM_W];
  assign ramRange  = ~|addr[ADDR_W-1:RAM_W];
  assign portRange = (addr[IO_W-1:PORT_SEL_W] == PORT_BASE[IO_W-1:PORT_SEL_W]);

  assign romHit = memCycle & romRange;
  assign romCsN = ~romHit;
  assign ramCsN = ~(memCycle & ramRange);
  assign ppiCsN = ~(ioCycle & portRange);
  assign regSel = addr[PORT_SEL_W-1:0];

  assign decG1     = addr[ADDR_W-1];
  assign decG2aN   = ~memCycle;
  assign decG2bN   = ~(&addr[ADDR_W-2:ROM_W]);
  assign decEnable = decG1 & ~decG2aN & ~decG2bN;
  assign decIdx    = addr[SUB_W+IDX_W-1:SUB_W];

  for (genvar k = 0; k < DEC_N; k++) begin : g_subSel
    assign romSubCsN[k] = ~(decEnable & (decIdx == IDX_W'(k)));
  end
endmodule

// File: rtl/bus_decoder.sv
module bus_decoder
  import bus_decoder_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ioSel,
  input  logic              rdN,
  input  logic              wrN,
  output logic              memRdN,
  output logic              memWrN,
  output logic              ioRdN,
  output logic              ioWrN,
  output logic              romCsN,
  output logic              ramCsN,
  output logic              ppiCsN,
  output logic [7:0]        romSubCsN,
  output logic [1:0]        regSel,
  output logic              ready
);
  cmdStrobes_t cmd;
  logic romHit;

  bus_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ioSel(ioSel), .rdN(rdN), .wrN(wrN),
    .romHit(romHit), .cmd(cmd), .ready(ready)
  );

  bus_addr_dp #(.ADDR_W(ADDR_W)) u_dp (
    .addr(addr), .cmd(cmd), .romCsN(romCsN), .ramCsN(ramCsN),
    .ppiCsN(ppiCsN), .romSubCsN(romSubCsN), .regSel(regSel),
    .romHit(romHit)
  );

  assign memRdN = ~cmd.memRd;
  assign memWrN = ~cmd.memWr;
  assign ioRdN  = ~cmd.ioRd;
  assign ioWrN  = ~cmd.ioWr;
endmodule

// File: rtl/bus_decoder_chk.sv
module bus_decoder_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rdN,
  input logic       wrN,
  input logic       memRdN,
  input logic       memWrN,
  input logic       ioRdN,
  input logic       ioWrN,
  input logic       romCsN,
  input logic       ramCsN,
  input logic       ppiCsN,
  input logic [7:0] romSubCsN,
  input logic       ready
);
  p_cmd_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~{memRdN, memWrN, ioRdN, ioWrN}))
    else $error("R1 more than one command strobe");

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdN == wrN) |-> (&{memRdN, memWrN, ioRdN, ioWrN, romCsN, ramCsN, ppiCsN}))
    else $error("R2 activity while idle");

  p_single_select_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~{romCsN, ramCsN, ppiCsN}))
    else $error("R6 overlapping selects");

  p_sub_in_rom_r7: assert property (@(posedge clk) disable iff (!rstN)
    (romCsN == 1'b0) == ($countones(~romSubCsN) == 1))
    else $error("R7 sub-select mismatch");

  p_wait_one_clock_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ready) |=> ready)
    else $error("R8 wait longer than one clock");

  p_wait_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ready) |-> $past(!romCsN))
    else $error("R8 wait without ROM access");

  p_fast_no_wait_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!ramCsN && $past(!ramCsN)) |-> ready)
    else $error("R9 wait on SRAM");

  always_comb begin
    if (!rstN) p_reset_ready_r10: assert (ready) else $error("R10 ready low in reset");
  end
endmodule

bind bus_decoder bus_decoder_chk u_chk (
  .clk(clk), .rstN(rstN), .rdN(rdN), .wrN(wrN),
  .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN), .ioWrN(ioWrN),
  .romCsN(romCsN), .ramCsN(ramCsN), .ppiCsN(ppiCsN),
  .romSubCsN(romSubCsN), .ready(ready)
);

// File: tb/tb_bus_decoder.sv
`timescale 1ns/1ps
module tb_bus_decoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [19:0] addr = '0;
  logic ioSel = 1'b0;
  logic rdN = 1'b1;
  logic wrN = 1'b1;
  logic memRdN, memWrN, ioRdN, ioWrN, romCsN, ramCsN, ppiCsN, ready;
  logic [7:0] romSubCsN;
  logic [1:0] regSel;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_decoder dut (
    .clk(clk), .rstN(rstN), .addr(addr), .ioSel(ioSel), .rdN(rdN), .wrN(wrN),
    .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN), .ioWrN(ioWrN),
    .romCsN(romCsN), .ramCsN(ramCsN), .ppiCsN(ppiCsN),
    .romSubCsN(romSubCsN), .regSel(regSel), .ready(ready)
  );

  typedef struct {
    logic [3:0] cmdN;
    logic [2:0] csN;
    logic [7:0] subN;
    logic [1:0] regSel;
    logic       ready;
    string      tag;
  } item_t;

  item_t sbq[$];

  // Expected combinational outputs from the requirements
  function automatic item_t model(logic [19:0] a, logic io, logic rd, logic wr);
    item_t it;
    logic rdA, wrA, memAny, ioAny, rom, ram, ppi;
    rdA = !rd && wr;
    wrA = rd && !wr;
    memAny = !io && (rdA || wrA);
    ioAny  = io && (rdA || wrA);
    rom = memAny && (a >= 20'hF8000);
    ram = memAny && (a <= 20'h7FFFF);
    ppi = ioAny && (a[15:0] >= 16'h0060) && (a[15:0] <= 16'h0063);
    it.cmdN = ~{!io && rdA, !io && wrA, io && rdA, io && wrA};
    it.csN = ~{rom, ram, ppi};
    it.subN = rom ? ~(8'b1 << a[15:13]) : 8'hFF;
    it.regSel = a[1:0];
    it.ready = 1'b1;
    it.tag = "";
    return it;
  endfunction

  task automatic drive(input logic [19:0] a, input logic io, input logic rd,
                       input logic wr, input logic expRdy, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    addr = a; ioSel = io; rdN = rd; wrN = wr;
    it = model(a, io, rd, wr);
    it.ready = expRdy;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(20'h00000, 1'b0, 1'b1, 1'b1, 1'b1, "R2");
  endtask

  // Monitor: compare away from the active edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t e;
      e = sbq.pop_front();
      vectors++;
      if ({memRdN, memWrN, ioRdN, ioWrN} !== e.cmdN ||
          {romCsN, ramCsN, ppiCsN} !== e.csN || romSubCsN !== e.subN ||
          regSel !== e.regSel || ready !== e.ready) begin
        miscompares++;
        $display("FAIL %s: got cmd=%b cs=%b sub=%h reg=%0d rdy=%b exp cmd=%b cs=%b sub=%h reg=%0d rdy=%b",
                 e.tag, {memRdN, memWrN, ioRdN, ioWrN}, {romCsN, ramCsN, ppiCsN},
                 romSubCsN, regSel, ready, e.cmdN, e.csN, e.subN, e.regSel, e.ready);
      end
    end
  end

  initial begin
    // R10: reset holds READY high even with a ROM strobe present
    drive(20'hFFFF0, 1'b0, 1'b0, 1'b1, 1'b1, "R10");
    drive(20'hFFFF0, 1'b0, 1'b0, 1'b1, 1'b1, "R10");
    drive(20'h00000, 1'b0, 1'b1, 1'b1, 1'b1, "R10");
    @(posedge clk); #1 rstN = 1'b1;
    idle(2);
    // R1 R4: SRAM read and write, R9 no wait on held SRAM access
    drive(20'h00000, 1'b0, 1'b0, 1'b1, 1'b1, "R4");
    drive(20'h00000, 1'b0, 1'b0, 1'b1, 1'b1, "R9");
    drive(20'h00000, 1'b0, 1'b0, 1'b1, 1'b1, "R9");
    drive(20'h7FFFF, 1'b0, 1'b1, 1'b0, 1'b1, "R1");
    drive(20'h12345, 1'b0, 1'b1, 1'b0, 1'b1, "R1");
    // R2: both strobes low at a ROM address is idle, no wait
    drive(20'hFFFF0, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
    drive(20'hFFFF0, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
    idle(1);
    // R3 R7 R8: ROM read at reset location held 3 clocks
    drive(20'hFFFF0, 1'b0, 1'b0, 1'b1, 1'b1, "R3");
    drive(20'hFFFF0, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
    drive(20'hFFFF0, 1'b0, 1'b0, 1'b1, 1'b1, "R8");
    idle(1);
    // R7: lowest ROM sub-bank, then re-entry after one idle clock
    drive(20'hF8000, 1'b0, 1'b0, 1'b1, 1'b1, "R7");
    drive(20'hF8000, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
    idle(1);
    drive(20'hFA000, 1'b0, 1'b1, 1'b0, 1'b1, "R7");
    drive(20'hFA000, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
    drive(20'hFDFFF, 1'b0, 1'b1, 1'b0, 1'b1, "R7");
    // R8 R9: ROM straight into SRAM with no idle clock
    idle(1);
    drive(20'hFC000, 1'b0, 1'b0, 1'b1, 1'b1, "R8");
    drive(20'hFC000, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
    drive(20'h40000, 1'b0, 1'b0, 1'b1, 1'b1, "R9");
    drive(20'h40000, 1'b0, 1'b0, 1'b1, 1'b1, "R9");
    // R5: unmapped gap edges
    drive(20'h80000, 1'b0, 1'b0, 1'b1, 1'b1, "R5");
    drive(20'h80000, 1'b0, 1'b0, 1'b1, 1'b1, "R5");
    drive(20'hF7FFF, 1'b0, 1'b1, 1'b0, 1'b1, "R5");
    drive(20'hF7FFF, 1'b0, 1'b1, 1'b0, 1'b1, "R5");
    // R6: peripheral window and its neighbours
    drive(20'h00060, 1'b1, 1'b0, 1'b1, 1'b1, "R6");
    drive(20'h00063, 1'b1, 1'b1, 1'b0, 1'b1, "R6");
    drive(20'hA0061, 1'b1, 1'b0, 1'b1, 1'b1, "R6");
    drive(20'h00064, 1'b1, 1'b0, 1'b1, 1'b1, "R6");
    drive(20'h0005F, 1'b1, 1'b1, 1'b0, 1'b1, "R6");
    drive(20'h00062, 1'b0, 1'b0, 1'b1, 1'b1, "R6");
    drive(20'hFFFF2, 1'b1, 1'b0, 1'b1, 1'b1, "R9");
    drive(20'hFFFF2, 1'b1, 1'b0, 1'b1, 1'b1, "R9");
    drive(20'h00061, 1'b1, 1'b0, 1'b0, 1'b1, "R2");
    idle(2);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got no completion, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule